// File: doc/BRIEF.md
# FIFO-Driven I2C Bus Master

This block is an I2C bus master that software runs entirely through a small register window. Software queues words into a transmit queue and later collects received bytes from a receive queue. The first queued word is the target address byte: the 7-bit address sits in bits 7:1 and bit 0 selects the direction (1 = read, 0 = write). A write to the control register with the launch bit set starts the transaction. Every later transmit word is either a data byte to send or, in a read, a placeholder whose only job is to pace one incoming byte. A flag in bit 8 of a transmit word marks it as the final one, after which the master issues STOP.

Sticky event flags report completion, address refusal, data refusal and loss of arbitration. A clock prescaler produces a base tick, and a timing register sets the length of each bus phase in base ticks. Both bus lines are open drain: the block only ever pulls a line low or lets it float.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset the status register reads 0x3 (bit0 transmit empty = 1, bit1 receive empty = 1, bit2 enabled = 0, bit3 busy = 0), the event register reads 0, and neither bus line is pulled low.
- R2: Register map: 0 data, 1 control, 2 status, 3 events, 4 timing. Control bit0 is enable, bit1 is launch, and bit2 is flush. A launch while enabled and idle with a non-empty transmit queue issues START and then sends the first queued word unchanged as the address byte.
- R3: In a write, the transmit words after the address go out MSB first in queue order. The word with bit 8 set is the last one: STOP follows its acknowledge, and event bit0 (done) is set.
- R4: In a read, each transmit word after the address clocks in exactly one byte, which is pushed into the receive queue. The master acknowledges every such byte except the stop-flagged one, which it refuses (NAK).
- R5: If the address byte is refused, the master sends STOP and flushes the transmit queue. It sets event bit1 and does not set done.
- R6: If a data byte in a write is refused, the master sends STOP and discards the remaining transmit words. It sets event bit2 and does not set done.
- R7: If SDA reads low at the end of an SCL-high phase while the master is sending a 1, the master releases both lines at once without sending STOP. It flushes the transmit queue, sets event bit3 and does not set done.
- R8: Writing the event register clears exactly the event bits written as 1 and leaves the others unchanged.
- R9: The control flush bit reads back as 1 in the cycle after it is written, then clears itself. Both queues are empty afterwards.
- R10: A launch is ignored while the block is disabled: the bus stays idle, busy stays 0, and the queued words remain.
- R11: Timing register fields are 4 bits each: [3:0] SCL low, [7:4] SCL high, [11:8] start/stop setup, [15:12] start/stop hold. A phase lasts (field+1) base ticks, and one base tick is DIV clocks (default 8).
- R12: Reading the data register returns the oldest received byte and removes it, and the status receive-empty bit rises once the queue is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue on the data register) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| scl_i | input | 1 | Sensed level of the clock line |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | Pull the clock line low when 1 |
| sda_oe | output | 1 | Pull the data line low when 1 |

## Verification
Arbitration loss is the hardest case to reach, because it needs a second driver that pulls SDA low at the exact bit where the master is sending a 1. The bench addresses target 0x7F, whose first bit is a 1. It waits for the first SCL fall after START and then holds an extra pull-down on the data line until the master gives up. Refusals come from a bench target model that acknowledges only one address and can be told to refuse one chosen data byte. The same model supplies the bytes returned in a read and logs the acknowledges the master sends.

// File: rtl/i2cm_pkg.sv
// Package: shared constants and types for the I2C master.
// Assumes register indices and event bit positions are fixed by software.
package i2cm_pkg;
    localparam int REGW = 16;         // register data width
    localparam int ADRW = 3;          // register index width
    localparam int TFW  = 4;          // width of one timing field
    localparam int TXW  = 9;          // transmit word: stop flag + byte
    localparam int EVW  = 4;          // number of event flags

    localparam logic [ADRW-1:0] RA_DATA = 3'd0;
    localparam logic [ADRW-1:0] RA_CTRL = 3'd1;
    localparam logic [ADRW-1:0] RA_STAT = 3'd2;
    localparam logic [ADRW-1:0] RA_EVT  = 3'd3;
    localparam logic [ADRW-1:0] RA_TIME = 3'd4;

    localparam int EV_DONE = 0;
    localparam int EV_ANAK = 1;
    localparam int EV_DNAK = 2;
    localparam int EV_ARB  = 3;

    typedef enum logic [3:0] {
        E_IDLE, E_SU, E_HD, E_LOW, E_HIGH, E_WAIT, E_P_LOW, E_P_SU, E_P_HD
    } eng_st_e;
endpackage

// File: rtl/i2cm_fifo.sv
// Module: synchronous queue with a clear that overrides push and pop.
// Assumes push when full and pop when empty are simply ignored.
module i2cm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Pointer wrap helper for any depth.
    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end
endmodule

// File: rtl/i2cm_tick.sv
// Module: prescaler giving a one-cycle base tick every DIV clocks.
// Assumes DIV >= 2; counter is held at zero while disabled.
module i2cm_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    // Free-running divider while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cm_engine.sv
// Module: bit-level bus sequencer (START, bytes with acknowledge, STOP).
// Assumes no clock stretching; all phase lengths come from timing fields
// counted in base ticks. Pops transmit words and pushes received bytes.
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int TW = TFW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           start,
    input  logic           tx_valid,
    input  logic [TXW-1:0] tx_word,
    output logic           tx_pop,
    output logic           rx_push,
    output logic [7:0]     rx_byte,
    input  logic [TW-1:0]  t_low,
    input  logic [TW-1:0]  t_high,
    input  logic [TW-1:0]  t_su,
    input  logic [TW-1:0]  t_hd,
    input  logic           sda_i,
    output logic           scl_oe,
    output logic           sda_oe,
    output logic           busy,
    output logic           ev_done,
    output logic           ev_anak,
    output logic           ev_dnak,
    output logic           ev_arb,
    output logic           tx_flush
);
    eng_st_e       st;
    logic [TW-1:0] cnt, lim;
    logic [3:0]    bitn;
    logic [7:0]    shreg;
    logic          last, rd_mode, is_addr, err;
    logic          timed, phase_end, sending, ack_end, nak_seen, want_next;

    // Phase limit selected by the current state.
    always_comb begin
        unique case (st)
            E_SU, E_P_SU:    lim = t_su;
            E_HD, E_P_HD:    lim = t_hd;
            E_LOW, E_P_LOW:  lim = t_low;
            E_HIGH:          lim = t_high;
            default:         lim = '0;
        endcase
    end

    assign timed     = (st != E_IDLE) && (st != E_WAIT);
    assign phase_end = timed && tick && (cnt == lim);
    assign sending   = is_addr || !rd_mode;
    assign ack_end   = (st == E_HIGH) && phase_end && (bitn == 4'd8);
    assign nak_seen  = ack_end && sending && sda_i;
    assign want_next = ack_end && !nak_seen && !last;

    assign ev_arb   = (st == E_HIGH) && phase_end && (bitn < 4'd8)
                      && sending && shreg[7] && !sda_i;
    assign ev_anak  = nak_seen && is_addr;
    assign ev_dnak  = nak_seen && !is_addr;
    assign ev_done  = (st == E_P_HD) && phase_end && !err;
    assign tx_flush = nak_seen || ev_arb;
    assign rx_push  = ack_end && !sending;
    assign rx_byte  = shreg;
    assign busy     = (st != E_IDLE);
    assign tx_pop   = ((st == E_IDLE) && start)
                      || (want_next && tx_valid)
                      || ((st == E_WAIT) && tx_valid);

    // Open-drain line drive per state and bit position.
    always_comb begin
        scl_oe = (st == E_LOW) || (st == E_WAIT) || (st == E_P_LOW);
        unique case (st)
            E_HD, E_P_LOW, E_P_SU: sda_oe = 1'b1;
            E_LOW, E_HIGH:
                sda_oe = (bitn < 4'd8) ? (sending && !shreg[7])
                                       : (!sending && !last);
            default:               sda_oe = 1'b0;
        endcase
    end

    // Sequencer state, phase counter and byte shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= E_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            last    <= 1'b0;
            rd_mode <= 1'b0;
            is_addr <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (timed && tick) cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
            unique case (st)
                E_IDLE: if (start) begin
                    shreg   <= tx_word[7:0];
                    last    <= tx_word[8];
                    rd_mode <= tx_word[0];
                    is_addr <= 1'b1;
                    err     <= 1'b0;
                    st      <= E_SU;
                end
                E_SU:  if (phase_end) st <= E_HD;
                E_HD:  if (phase_end) begin bitn <= '0; st <= E_LOW; end
                E_LOW: if (phase_end) st <= E_HIGH;
                E_HIGH: if (phase_end) begin
                    if (bitn < 4'd8) begin
                        if (ev_arb) st <= E_IDLE;
                        else begin
                            shreg <= {shreg[6:0], sda_i};
                            bitn  <= bitn + 1'b1;
                            st    <= E_LOW;
                        end
                    end else if (nak_seen) begin
                        err <= 1'b1;
                        st  <= E_P_LOW;
                    end else if (last) begin
                        st <= E_P_LOW;
                    end else if (tx_valid) begin
                        shreg   <= tx_word[7:0];
                        last    <= tx_word[8];
                        is_addr <= 1'b0;
                        bitn    <= '0;
                        st      <= E_LOW;
                    end else begin
                        st <= E_WAIT;
                    end
                end
                E_WAIT: if (tx_valid) begin
                    shreg   <= tx_word[7:0];
                    last    <= tx_word[8];
                    is_addr <= 1'b0;
                    bitn    <= '0;
                    st      <= E_LOW;
                end
                E_P_LOW: if (phase_end) st <= E_P_SU;
                E_P_SU:  if (phase_end) st <= E_P_HD;
                E_P_HD:  if (phase_end) st <= E_IDLE;
                default: st <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_ctrl.sv
// Module: top of the I2C master. Register window, both queues, event flags,
// prescaler and bus sequencer. Assumes one register access per cycle;
// reads are combinational and a data-register read pops the receive queue.
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [ADRW-1:0] reg_addr,
    input  logic [REGW-1:0] reg_wdata,
    output logic [REGW-1:0] reg_rdata,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            scl_oe,
    output logic            sda_oe
);
    localparam int TRW = 4 * TFW;

    logic           ctrl_en, flush_busy, tick;
    logic [TRW-1:0] timing;
    logic [EVW-1:0] ev_q, ev_set, ev_clr;
    logic           wr_data, wr_ctrl, wr_evt, wr_time, rd_data;
    logic           tx_empty, tx_full, rx_empty, rx_full;
    logic [TXW-1:0] tx_word;
    logic [7:0]     rx_dout, rx_byte;
    logic           tx_pop, rx_push, eng_start, eng_busy, eng_flush;
    logic           ev_done, ev_anak, ev_dnak, ev_arb;

    assign wr_data = reg_wr && (reg_addr == RA_DATA);
    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_evt  = reg_wr && (reg_addr == RA_EVT);
    assign wr_time = reg_wr && (reg_addr == RA_TIME);
    assign rd_data = reg_rd && (reg_addr == RA_DATA);

    assign eng_start = wr_ctrl && reg_wdata[1] && ctrl_en && !eng_busy
                       && !tx_empty && !flush_busy;

    // Control, flush request and timing registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en    <= 1'b0;
            flush_busy <= 1'b0;
            timing     <= '1;
        end else begin
            flush_busy <= wr_ctrl && reg_wdata[2];
            if (wr_ctrl) ctrl_en <= reg_wdata[0];
            if (wr_time) timing  <= reg_wdata[TRW-1:0];
        end
    end

    assign ev_set = {ev_arb, ev_dnak, ev_anak, ev_done};
    assign ev_clr = wr_evt ? reg_wdata[EVW-1:0] : '0;

    // Sticky events; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~ev_clr) | ev_set;
    end

    // Register read multiplexer.
    always_comb begin
        unique case (reg_addr)
            RA_DATA: reg_rdata = {{(REGW-8){1'b0}}, rx_dout};
            RA_CTRL: reg_rdata = {{(REGW-3){1'b0}}, flush_busy, 1'b0, ctrl_en};
            RA_STAT: reg_rdata = {{(REGW-4){1'b0}}, eng_busy, ctrl_en,
                                  rx_empty, tx_empty};
            RA_EVT:  reg_rdata = {{(REGW-EVW){1'b0}}, ev_q};
            RA_TIME: reg_rdata = REGW'(timing);
            default: reg_rdata = '0;
        endcase
    end

    i2cm_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_busy || eng_flush),
        .push  (wr_data && !tx_full),
        .din   (reg_wdata[TXW-1:0]),
        .pop   (tx_pop),
        .dout  (tx_word),
        .empty (tx_empty),
        .full  (tx_full)
    );

    i2cm_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_busy),
        .push  (rx_push && !rx_full),
        .din   (rx_byte),
        .pop   (rd_data),
        .dout  (rx_dout),
        .empty (rx_empty),
        .full  (rx_full)
    );

    i2cm_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl_en),
        .tick  (tick)
    );

    i2cm_engine #(.TW(TFW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (eng_start),
        .tx_valid (!tx_empty),
        .tx_word  (tx_word),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_byte  (rx_byte),
        .t_low    (timing[TFW-1:0]),
        .t_high   (timing[2*TFW-1:TFW]),
        .t_su     (timing[3*TFW-1:2*TFW]),
        .t_hd     (timing[4*TFW-1:3*TFW]),
        .sda_i    (sda_i),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .busy     (eng_busy),
        .ev_done  (ev_done),
        .ev_anak  (ev_anak),
        .ev_dnak  (ev_dnak),
        .ev_arb   (ev_arb),
        .tx_flush (eng_flush)
    );

    // The clock line level is not sensed: no clock stretching is supported.
    logic unused_scl;
    assign unused_scl = scl_i;
endmodule

// File: rtl/i2cm_ctrl_chk.sv
// Module: protocol checker for i2cm_ctrl, attached by bind below.
// Assumes it sees the top's internal engine, prescaler and queue signals.
module i2cm_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic eng_busy,
    input logic scl_oe,
    input logic sda_oe,
    input logic ev_arb,
    input logic ev_anak,
    input logic ev_dnak,
    input logic flush_busy,
    input logic tx_empty,
    input logic ctrl_en
);
    // R1: an idle sequencer never pulls a bus line.
    p_idle_lines_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (!scl_oe && !sda_oe));

    // R11: the base tick is a single-cycle pulse.
    p_tick_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7: arbitration loss frees both lines on the next cycle.
    p_arb_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb |=> (!scl_oe && !sda_oe));

    // R5 and R6: a refusal empties the transmit queue.
    p_nak_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_anak || ev_dnak) |=> tx_empty);

    // R9: the flush bit clears itself after one cycle.
    p_flush_selfclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> !flush_busy);

    // R10: a disabled, idle block stays idle.
    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !eng_busy) |=> !eng_busy);
endmodule

bind i2cm_ctrl i2cm_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .eng_busy   (eng_busy),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .ev_arb     (ev_arb),
    .ev_anak    (ev_anak),
    .ev_dnak    (ev_dnak),
    .flush_busy (flush_busy),
    .tx_empty   (tx_empty),
    .ctrl_en    (ctrl_en)
);

// File: tb/i2cm_ctrl_tb_top.sv
// Bench: scoreboard around i2cm_ctrl with a behavioural bus target.
// The driver queues the bytes the target must see; the target model pops
// and compares them as they arrive on the bus.
module i2cm_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        scl_oe, sda_oe;
    logic        slv_low = 1'b0, force_low = 1'b0;

    wire scl_line = !scl_oe;
    wire sda_line = !(sda_oe || slv_low || force_low);

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];

    localparam logic [6:0] SLV_ADDR = 7'h2A;

    always #4 clk = ~clk;

    i2cm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            reg_read(3'd2, s);
            if (!s[3]) return;
        end
    endtask

    // Behavioural target and line monitor.
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic       s_act = 1'b0, s_first = 1'b0, s_rd = 1'b0, s_mnak = 1'b0;
    logic [3:0] s_cnt = '0;
    logic [7:0] s_sh = '0, s_tx = '0, rd_val = 8'h3C;
    int         wr_idx = 0, nak_idx = -1, m_acks = 0, m_naks = 0;
    int         hi_run = 0, last_hi = 0, n_fall = 0;

    task automatic sb_compare(input string req, input logic [7:0] got);
        logic [7:0] e;
        if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: actual %0h expected none", req, got);
        end else begin
            e = exp_q.pop_front();
            check(req, {24'd0, got}, {24'd0, e});
        end
    endtask

    always @(negedge clk) begin
        p_scl <= scl_line;
        p_sda <= sda_line;
        hi_run <= scl_line ? hi_run + 1 : 0;
        if (p_scl && !scl_line) begin
            last_hi <= hi_run;
            n_fall  <= n_fall + 1;
        end
        if (!rst_n) begin
            s_act <= 1'b0; slv_low <= 1'b0;
        end else if (scl_line && p_scl && p_sda && !sda_line) begin
            s_act <= 1'b1; s_cnt <= '0; s_first <= 1'b1; s_rd <= 1'b0;
            s_mnak <= 1'b0; slv_low <= 1'b0; wr_idx <= 0;
        end else if (scl_line && p_scl && !p_sda && sda_line) begin
            s_act <= 1'b0; slv_low <= 1'b0;
        end else if (s_act && !p_scl && scl_line) begin
            s_cnt <= s_cnt + 1'b1;
            if (s_cnt < 4'd8) s_sh <= {s_sh[6:0], sda_line};
            else if (s_rd && !s_first) begin
                if (sda_line) begin m_naks <= m_naks + 1; s_mnak <= 1'b1; end
                else m_acks <= m_acks + 1;
            end
        end else if (s_act && p_scl && !scl_line) begin
            if (s_cnt == 4'd8) begin
                if (s_first) begin
                    sb_compare("R2", s_sh);
                    if (s_sh[7:1] == SLV_ADDR) begin
                        slv_low <= 1'b1; s_rd <= s_sh[0];
                    end else begin
                        s_act <= 1'b0; slv_low <= 1'b0;
                    end
                end else if (!s_rd) begin
                    sb_compare("R3", s_sh);
                    slv_low <= (wr_idx != nak_idx);
                    wr_idx  <= wr_idx + 1;
                end else slv_low <= 1'b0;
            end else if (s_cnt == 4'd9) begin
                s_cnt <= '0; s_first <= 1'b0;
                if (s_rd && !s_mnak) begin
                    s_tx <= rd_val; slv_low <= !rd_val[7];
                    rd_val <= rd_val + 1'b1;
                end else slv_low <= 1'b0;
            end else if (s_cnt != 4'd0 && s_rd && !s_first) begin
                slv_low <= !s_tx[7 - s_cnt];
            end
        end
    end

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int f0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);

        // R1: reset state
        reg_read(3'd2, d); check("R1 status", d, 16'h3);
        reg_read(3'd3, d); check("R1 events", d, 16'h0);
        check("R1 lines", {scl_line, sda_line}, 2'b11);

        // R10: launch while disabled is ignored
        reg_write(3'd4, 16'h0000);
        reg_write(3'd0, 16'h0054);
        f0 = n_fall;
        reg_write(3'd1, 16'h0002);
        repeat (200) @(posedge clk);
        reg_read(3'd2, d);
        check("R10 busy/txempty", {d[3], d[0]}, 2'b00);
        check("R10 no bus clocks", n_fall - f0, 0);

        // R9: flush self-clears, queues empty
        reg_write(3'd1, 16'h0004);
        reg_read(3'd1, d); check("R9 flush set", d[2], 1'b1);
        reg_read(3'd1, d); check("R9 flush clear", d[2], 1'b0);
        reg_read(3'd2, d); check("R9 empty", d[1:0], 2'b11);

        // R2/R3: write of three bytes
        reg_write(3'd1, 16'h0001);
        reg_read(3'd2, d); check("R2 enabled", d[2], 1'b1);
        exp_q.push_back(8'h54); exp_q.push_back(8'h11);
        exp_q.push_back(8'h22); exp_q.push_back(8'h33);
        reg_write(3'd0, 16'h0054); reg_write(3'd0, 16'h0011);
        reg_write(3'd0, 16'h0022); reg_write(3'd0, 16'h0133);
        reg_write(3'd1, 16'h0003);
        wait_idle();
        reg_read(3'd3, d); check("R3 done event", d, 16'h1);
        check("R3 all bytes seen", exp_q.size(), 0);
        check("R3 stop seen", s_act, 1'b0);
        reg_write(3'd3, 16'h000F);
        reg_read(3'd3, d); check("R8 clear all", d, 16'h0);

        // R4/R12: read of three bytes
        m_acks = 0; m_naks = 0; rd_val = 8'h3C;
        exp_q.push_back(8'h55);
        reg_write(3'd0, 16'h0055); reg_write(3'd0, 16'h0000);
        reg_write(3'd0, 16'h0000); reg_write(3'd0, 16'h0100);
        reg_write(3'd1, 16'h0003);
        wait_idle();
        reg_read(3'd3, d); check("R4 done event", d, 16'h1);
        check("R4 master acks", m_acks, 2);
        check("R4 master nak on last", m_naks, 1);
        reg_read(3'd2, d); check("R12 rx not empty", d[1], 1'b0);
        for (int k = 0; k < 3; k++) begin
            reg_read(3'd0, d); check("R12 rx byte", d[7:0], 8'h3C + k);
        end
        reg_read(3'd2, d); check("R12 rx empty", d[1], 1'b1);
        reg_write(3'd3, 16'h000F);

        // R5: address refused
        exp_q.push_back(8'h22);
        reg_write(3'd0, 16'h0022); reg_write(3'd0, 16'h00AA);
        reg_write(3'd0, 16'h01BB);
        reg_write(3'd1, 16'h0003);
        wait_idle();
        reg_read(3'd3, d); check("R5 addr nak only", d, 16'h2);
        reg_read(3'd2, d); check("R5 tx flushed", d[0], 1'b1);
        check("R5 lines free", {scl_line, sda_line}, 2'b11);

        // R6: second data byte refused, rest discarded
        nak_idx = 1;
        exp_q.push_back(8'h54); exp_q.push_back(8'h01); exp_q.push_back(8'h02);
        reg_write(3'd0, 16'h0054); reg_write(3'd0, 16'h0001);
        reg_write(3'd0, 16'h0002); reg_write(3'd0, 16'h0003);
        reg_write(3'd0, 16'h0104);
        reg_write(3'd1, 16'h0003);
        wait_idle();
        nak_idx = -1;
        reg_read(3'd3, d); check("R6 data nak, no done", d, 16'h6);
        reg_read(3'd2, d); check("R6 tx flushed", d[0], 1'b1);
        check("R6 bytes seen", exp_q.size(), 0);

        // R8: clear only the address-refusal bit
        reg_write(3'd3, 16'h0002);
        reg_read(3'd3, d); check("R8 partial clear", d, 16'h4);
        reg_write(3'd3, 16'h000F);

        // R7: arbitration lost on the first address bit
        reg_write(3'd0, 16'h00FE); reg_write(3'd0, 16'h0100);
        reg_write(3'd1, 16'h0003);
        while (scl_line) @(negedge clk);
        force_low = 1'b1;
        wait_idle();
        check("R7 lines released", {scl_oe, sda_oe}, 2'b00);
        force_low = 1'b0;
        repeat (4) @(posedge clk);
        reg_read(3'd3, d); check("R7 arb event only", d, 16'h8);
        reg_read(3'd2, d); check("R7 tx flushed", d[0], 1'b1);
        reg_write(3'd3, 16'h000F);

        // R11: SCL high phase of (2+1) ticks of 8 clocks
        reg_write(3'd4, 16'h0020);
        exp_q.push_back(8'h54); exp_q.push_back(8'h77);
        reg_write(3'd0, 16'h0054); reg_write(3'd0, 16'h0177);
        reg_write(3'd1, 16'h0003);
        wait_idle();
        check("R11 high width", last_hi, 24);
        reg_read(3'd3, d); check("R11 done", d, 16'h1);
        check("R11 bytes seen", exp_q.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule